// File: doc/BRIEF.md
# Reaction Channel Status and Error Flags

This block holds the status word of one output-reaction channel. It catches error events reported by the channel datapath in sticky flags. Each flag is gated by the channel state. A timer-allocation failure or a badly terminated modulation window counts only while the channel is active. A resource-bounds violation counts only while the channel is enabled.

The block also latches two events that arrive from outside the channel: an ADC maximum-limit hit and an open-circuit detection. It reflects the three channel output levels live in the same word. Software reads the word through a simple register port and clears flags by writing ones to dedicated bit positions. When a set event and a clear write land in the same cycle, the set event wins.

The resource check compares each bank address against its configured depth. It also checks the control-word pointer step at the last word, the input-router selection, and the forbidden pairing of sequence-advance and modulation-mode codes that both claim the hold-off timer. The flag is re-evaluated every cycle, so it cannot be cleared while its cause persists.

Top module: `rxn_chan_status`

## Requirements
- R1: Bit 6 (timer allocation error) becomes 1 on the clock edge after a cycle in which `tmr_alloc_fail` is 1 and `chan_active` is 1. It stays 1 until cleared. A failure strobe while `chan_active` is 0 leaves it unchanged.
- R2: Bit 7 (sequence error) becomes 1 on the edge after a cycle with `mod_win_close`=1, `chan_active`=1 and `seq_adv_code` not equal to 2'b00. A window close with code 2'b00, or one while inactive, leaves it unchanged.
- R3: Bit 8 (resource allocation error) becomes 1 on the edge after a cycle with `chan_enabled`=1 and any of these conditions. It is never set while `chan_enabled` is 0. The conditions are:
  - `cw_addr` >= CW_DEPTH;
  - `cw_step`=1 with `cw_addr`+1 >= CW_DEPTH;
  - `thr_addr` >= THR_DEPTH, `hold_addr` >= HOLD_DEPTH or `tmr_addr` >= TMR_DEPTH;
  - `route_sel` >= ROUTE_CHANS;
  - `seq_adv_code`=2'b10 together with `mod_mode`=2'b01.
- R4: Read bits 11, 10, 9 show `out_c`, `out_b`, `out_a` combinationally in every channel state, with no clock edge needed.
- R5: Bits 2–5, 12–18 and 21–31 read as 0. Bits 19 and 20 read as 0 even after a 1 is written there. Writing to any bit other than 6, 7, 8, 19 or 20 changes no flag.
- R6: Writing 1 to bit 19 clears the ADC-limit flag (read bit 0), and writing 1 to bit 20 clears the open-circuit flag (read bit 1), from the next edge. A write with those bits 0 leaves the flags unchanged.
- R7: Writing 1 to bit 6, 7 or 8 clears that flag alone from the next edge.
- R8: A set condition present in the same cycle as a clear write leaves the flag at 1. The resource error therefore stays set while its cause persists.
- R9: `adc_max_set` sets read bit 0 and `open_ckt_set` sets read bit 1 on the next edge, independent of the channel state.
- R10: Synchronous reset clears every flag. `reg_rdata` shows the status word in the same cycle `reg_rd` is 1 and is all zero while `reg_rd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_enabled | input | 1 | Channel enabled state |
| chan_active | input | 1 | Channel active state |
| tmr_alloc_fail | input | 1 | Shared-timer allocation failed this cycle |
| mod_win_close | input | 1 | Modulation time window closes this cycle |
| seq_adv_code | input | 2 | Current sequence-advance code |
| mod_mode | input | 2 | Current modulation mode code |
| cw_addr | input | CW_AW | Control-word pointer |
| cw_step | input | 1 | Control-word pointer increments this cycle |
| thr_addr | input | THR_AW | Threshold bank address |
| hold_addr | input | HOLD_AW | Hold-off timer bank address |
| tmr_addr | input | TMR_AW | Shared timer bank address |
| route_sel | input | ROUTE_W | Input router channel selection |
| out_a | input | 1 | Channel output a level |
| out_b | input | 1 | Channel output b level |
| out_c | input | 1 | Channel output c level |
| adc_max_set | input | 1 | ADC maximum-limit event |
| open_ckt_set | input | 1 | Open-circuit detection event |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |

## Verification
The state-gated flags are swept over every combination of enable, active, failure strobe, window close and all four sequence codes. This separates the state gate from the code test. Each resource cause is applied alone and paired with a just-in-range neighbour, both enabled and disabled, which tells an off-by-one bound apart from a missing cause. Collisions of set and clear on every flag, a persistent resource cause, and writes of ones to every non-clear bit separate set priority from plain clearing. All eight output patterns in all four states confirm the live monitor field and its bit order.

// File: rtl/rxn_status_pkg.sv
package rxn_status_pkg;

    localparam int REG_W      = 32;
    localparam int NUM_FLAGS  = 5;

    // flag indices within the internal flag vector
    localparam int FLG_MAXL = 0;
    localparam int FLG_OCD  = 1;
    localparam int FLG_TAE  = 2;
    localparam int FLG_SQE  = 3;
    localparam int FLG_RAE  = 4;

    localparam int OUTMON_LSB = 9;

    typedef enum logic [1:0] {
        SEQ_STAY    = 2'b00,
        SEQ_STEP    = 2'b01,
        SEQ_HOLDOFF = 2'b10,
        SEQ_OTHER   = 2'b11
    } seq_code_e;

    typedef enum logic [1:0] {
        MOD_PLAIN   = 2'b00,
        MOD_HOLDOFF = 2'b01,
        MOD_ALT_A   = 2'b10,
        MOD_ALT_B   = 2'b11
    } mod_mode_e;

    typedef struct packed {
        logic cw_range;
        logic cw_step;
        logic thr;
        logic hold;
        logic tmr;
        logic route;
        logic mode_clash;
    } res_viol_t;

    typedef struct packed {
        logic c;
        logic b;
        logic a;
    } out_lvl_t;

    function automatic int flag_rd_pos(input int idx);
        case (idx)
            FLG_MAXL: return 0;
            FLG_OCD:  return 1;
            FLG_TAE:  return 6;
            FLG_SQE:  return 7;
            default:  return 8;
        endcase
    endfunction

    function automatic int flag_clr_pos(input int idx);
        case (idx)
            FLG_MAXL: return 19;
            FLG_OCD:  return 20;
            FLG_TAE:  return 6;
            FLG_SQE:  return 7;
            default:  return 8;
        endcase
    endfunction

    function automatic logic [NUM_FLAGS-1:0] clr_from_word(input logic [REG_W-1:0] w);
        logic [NUM_FLAGS-1:0] c;
        for (int i = 0; i < NUM_FLAGS; i++) c[i] = w[flag_clr_pos(i)];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] build_image(input logic [NUM_FLAGS-1:0] f,
                                                     input out_lvl_t o);
        logic [REG_W-1:0] img;
        img = '0;
        for (int i = 0; i < NUM_FLAGS; i++) img[flag_rd_pos(i)] = f[i];
        img[OUTMON_LSB +: 3] = o;
        return img;
    endfunction

    function automatic logic [REG_W-1:0] clear_mask();
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_FLAGS; i++) m[flag_clr_pos(i)] = 1'b1;
        return m;
    endfunction

    function automatic logic [REG_W-1:0] defined_rd_mask();
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_FLAGS; i++) m[flag_rd_pos(i)] = 1'b1;
        m[OUTMON_LSB +: 3] = 3'b111;
        return m;
    endfunction

endpackage

// File: rtl/rxn_bound_chk.sv
module rxn_bound_chk #(
    parameter int          W     = 4,
    parameter int unsigned LIMIT = 8
) (
    input  logic [W-1:0] val,
    output logic         over
);
    always_comb over = (32'(val) >= 32'(LIMIT));
endmodule

// File: rtl/rxn_res_check.sv
module rxn_res_check
    import rxn_status_pkg::*;
#(
    parameter int CW_DEPTH    = 12,
    parameter int CW_AW       = 4,
    parameter int THR_DEPTH   = 6,
    parameter int THR_AW      = 3,
    parameter int HOLD_DEPTH  = 5,
    parameter int HOLD_AW     = 3,
    parameter int TMR_DEPTH   = 4,
    parameter int TMR_AW      = 3,
    parameter int ROUTE_CHANS = 6,
    parameter int ROUTE_W     = 3
) (
    input  logic [CW_AW-1:0]   cw_addr,
    input  logic               cw_step,
    input  logic [THR_AW-1:0]  thr_addr,
    input  logic [HOLD_AW-1:0] hold_addr,
    input  logic [TMR_AW-1:0]  tmr_addr,
    input  logic [ROUTE_W-1:0] route_sel,
    input  logic [1:0]         seq_adv_code,
    input  logic [1:0]         mod_mode,
    output res_viol_t          viol,
    output logic               any_viol
);
    localparam int CW_NW = CW_AW + 1;

    logic [CW_NW-1:0] cw_next;
    logic cw_over, cw_next_over, thr_over, hold_over, tmr_over, route_over;
    seq_code_e seq_code;
    mod_mode_e mode_code;

    always_comb cw_next = {1'b0, cw_addr} + CW_NW'(1);

    rxn_bound_chk #(.W(CW_AW),   .LIMIT(CW_DEPTH))    u_cw    (.val(cw_addr),   .over(cw_over));
    rxn_bound_chk #(.W(CW_NW),   .LIMIT(CW_DEPTH))    u_cwn   (.val(cw_next),   .over(cw_next_over));
    rxn_bound_chk #(.W(THR_AW),  .LIMIT(THR_DEPTH))   u_thr   (.val(thr_addr),  .over(thr_over));
    rxn_bound_chk #(.W(HOLD_AW), .LIMIT(HOLD_DEPTH))  u_hold  (.val(hold_addr), .over(hold_over));
    rxn_bound_chk #(.W(TMR_AW),  .LIMIT(TMR_DEPTH))   u_tmr   (.val(tmr_addr),  .over(tmr_over));
    rxn_bound_chk #(.W(ROUTE_W), .LIMIT(ROUTE_CHANS)) u_route (.val(route_sel), .over(route_over));

    always_comb begin
        seq_code        = seq_code_e'(seq_adv_code);
        mode_code       = mod_mode_e'(mod_mode);
        viol.cw_range   = cw_over;
        viol.cw_step    = cw_step & cw_next_over;
        viol.thr        = thr_over;
        viol.hold       = hold_over;
        viol.tmr        = tmr_over;
        viol.route      = route_over;
        viol.mode_clash = (seq_code == SEQ_HOLDOFF) && (mode_code == MOD_HOLDOFF);
        any_viol        = |viol;
    end
endmodule

// File: rtl/rxn_sticky_bank.sv
module rxn_sticky_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] q
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst)             bit_q <= 1'b0;
            else if (set_vec[g]) bit_q <= 1'b1;
            else if (clr_vec[g]) bit_q <= 1'b0;
        end
        assign q[g] = bit_q;
    end
endmodule

// File: rtl/rxn_clr_decode.sv
module rxn_clr_decode
    import rxn_status_pkg::*;
(
    input  logic                 reg_wr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [NUM_FLAGS-1:0] clr_vec
);
    always_comb clr_vec = reg_wr ? clr_from_word(reg_wdata) : '0;
endmodule

// File: rtl/rxn_readback.sv
module rxn_readback
    import rxn_status_pkg::*;
(
    input  logic                 reg_rd,
    input  logic [NUM_FLAGS-1:0] flags,
    input  out_lvl_t             outs,
    output logic [REG_W-1:0]     reg_rdata
);
    always_comb reg_rdata = reg_rd ? build_image(flags, outs) : '0;
endmodule

// File: rtl/rxn_chan_status.sv
module rxn_chan_status
    import rxn_status_pkg::*;
#(
    parameter int CW_DEPTH    = 12,
    parameter int CW_AW       = 4,
    parameter int THR_DEPTH   = 6,
    parameter int THR_AW      = 3,
    parameter int HOLD_DEPTH  = 5,
    parameter int HOLD_AW     = 3,
    parameter int TMR_DEPTH   = 4,
    parameter int TMR_AW      = 3,
    parameter int ROUTE_CHANS = 6,
    parameter int ROUTE_W     = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               chan_enabled,
    input  logic               chan_active,
    input  logic               tmr_alloc_fail,
    input  logic               mod_win_close,
    input  logic [1:0]         seq_adv_code,
    input  logic [1:0]         mod_mode,
    input  logic [CW_AW-1:0]   cw_addr,
    input  logic               cw_step,
    input  logic [THR_AW-1:0]  thr_addr,
    input  logic [HOLD_AW-1:0] hold_addr,
    input  logic [TMR_AW-1:0]  tmr_addr,
    input  logic [ROUTE_W-1:0] route_sel,
    input  logic               out_a,
    input  logic               out_b,
    input  logic               out_c,
    input  logic               adc_max_set,
    input  logic               open_ckt_set,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata
);
    res_viol_t            viol;
    logic                 res_bad;
    logic [NUM_FLAGS-1:0] set_vec;
    logic [NUM_FLAGS-1:0] clr_vec;
    logic [NUM_FLAGS-1:0] flag_q;
    out_lvl_t             outs;
    seq_code_e            seq_now;

    rxn_res_check #(
        .CW_DEPTH(CW_DEPTH), .CW_AW(CW_AW),
        .THR_DEPTH(THR_DEPTH), .THR_AW(THR_AW),
        .HOLD_DEPTH(HOLD_DEPTH), .HOLD_AW(HOLD_AW),
        .TMR_DEPTH(TMR_DEPTH), .TMR_AW(TMR_AW),
        .ROUTE_CHANS(ROUTE_CHANS), .ROUTE_W(ROUTE_W)
    ) u_res (
        .cw_addr(cw_addr), .cw_step(cw_step), .thr_addr(thr_addr),
        .hold_addr(hold_addr), .tmr_addr(tmr_addr), .route_sel(route_sel),
        .seq_adv_code(seq_adv_code), .mod_mode(mod_mode),
        .viol(viol), .any_viol(res_bad)
    );

    // state gating of each set source
    always_comb begin
        seq_now           = seq_code_e'(seq_adv_code);
        set_vec           = '0;
        set_vec[FLG_MAXL] = adc_max_set;
        set_vec[FLG_OCD]  = open_ckt_set;
        set_vec[FLG_TAE]  = chan_active & tmr_alloc_fail;
        set_vec[FLG_SQE]  = chan_active & mod_win_close & (seq_now != SEQ_STAY);
        set_vec[FLG_RAE]  = chan_enabled & res_bad;
        outs.a            = out_a;
        outs.b            = out_b;
        outs.c            = out_c;
    end

    rxn_clr_decode u_clr (
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .clr_vec(clr_vec)
    );

    rxn_sticky_bank #(.N(NUM_FLAGS)) u_flags (
        .clk(clk), .rst(rst), .set_vec(set_vec), .clr_vec(clr_vec), .q(flag_q)
    );

    rxn_readback u_rd (
        .reg_rd(reg_rd), .flags(flag_q), .outs(outs), .reg_rdata(reg_rdata)
    );
endmodule

// File: rtl/rxn_chan_status_chk.sv
module rxn_chan_status_chk
    import rxn_status_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 chan_enabled,
    input logic                 chan_active,
    input logic                 tmr_alloc_fail,
    input logic                 mod_win_close,
    input logic [1:0]           seq_adv_code,
    input logic                 out_a,
    input logic                 out_b,
    input logic                 out_c,
    input logic                 adc_max_set,
    input logic                 open_ckt_set,
    input logic                 reg_wr,
    input logic                 reg_rd,
    input logic [31:0]          reg_wdata,
    input logic [31:0]          reg_rdata,
    input logic [NUM_FLAGS-1:0] flags
);
    localparam logic [31:0] RSVD_MASK = ~defined_rd_mask();
    localparam logic [31:0] CLR_MASK  = clear_mask();

    AST_TAE_SRC: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[FLG_TAE]) |-> $past(chan_active && tmr_alloc_fail)); // R1

    AST_SQE_SET: assert property (@(posedge clk) disable iff (rst)
        (chan_active && mod_win_close && seq_adv_code != 2'b00) |=> flags[FLG_SQE]); // R2

    AST_SQE_SRC: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[FLG_SQE]) |-> $past(chan_active && mod_win_close && seq_adv_code != 2'b00)); // R2

    AST_RAE_GATE: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[FLG_RAE]) |-> $past(chan_enabled)); // R3

    AST_OUTMON_LIVE: assert property (@(posedge clk) disable iff (rst)
        reg_rd |-> reg_rdata[11:9] == {out_c, out_b, out_a}); // R4

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata & RSVD_MASK) == 32'd0); // R5

    AST_NONCLR_WR_NOP: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && (reg_wdata & CLR_MASK) == 32'd0 && !adc_max_set && !open_ckt_set
         && !tmr_alloc_fail && !mod_win_close && !chan_enabled) |=> $stable(flags)); // R5

    AST_MAXL_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_wdata[19] && !adc_max_set) |=> !flags[FLG_MAXL]); // R6

    AST_TAE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_wdata[6] && !(chan_active && tmr_alloc_fail)) |=> !flags[FLG_TAE]); // R7

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        adc_max_set |=> flags[FLG_MAXL]); // R8

    AST_OCD_SET: assert property (@(posedge clk) disable iff (rst)
        open_ckt_set |=> flags[FLG_OCD]); // R9

    AST_IDLE_READ: assert property (@(posedge clk) disable iff (rst)
        !reg_rd |-> reg_rdata == 32'd0); // R10

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> flags == '0); // R10
endmodule

bind rxn_chan_status rxn_chan_status_chk u_chk (
    .clk(clk), .rst(rst), .chan_enabled(chan_enabled), .chan_active(chan_active),
    .tmr_alloc_fail(tmr_alloc_fail), .mod_win_close(mod_win_close),
    .seq_adv_code(seq_adv_code), .out_a(out_a), .out_b(out_b), .out_c(out_c),
    .adc_max_set(adc_max_set), .open_ckt_set(open_ckt_set), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .flags(flag_q)
);

// File: tb/rxn_chan_status_tb.sv
`timescale 1ns/1ps
module rxn_chan_status_tb;
    localparam int CW_DEPTH = 12, CW_AW = 4;
    localparam int THR_DEPTH = 6, THR_AW = 3;
    localparam int HOLD_DEPTH = 5, HOLD_AW = 3;
    localparam int TMR_DEPTH = 4, TMR_AW = 3;
    localparam int ROUTE_CHANS = 6, ROUTE_W = 3;
    localparam logic [31:0] CLR_ALL = 32'h001801C0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic chan_enabled = 0, chan_active = 0, tmr_alloc_fail = 0, mod_win_close = 0;
    logic [1:0] seq_adv_code = 0, mod_mode = 0;
    logic [CW_AW-1:0] cw_addr = 0;
    logic cw_step = 0;
    logic [THR_AW-1:0] thr_addr = 0;
    logic [HOLD_AW-1:0] hold_addr = 0;
    logic [TMR_AW-1:0] tmr_addr = 0;
    logic [ROUTE_W-1:0] route_sel = 0;
    logic out_a = 0, out_b = 0, out_c = 0;
    logic adc_max_set = 0, open_ckt_set = 0;
    logic reg_wr = 0, reg_rd = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    rxn_chan_status #(
        .CW_DEPTH(CW_DEPTH), .CW_AW(CW_AW), .THR_DEPTH(THR_DEPTH), .THR_AW(THR_AW),
        .HOLD_DEPTH(HOLD_DEPTH), .HOLD_AW(HOLD_AW), .TMR_DEPTH(TMR_DEPTH), .TMR_AW(TMR_AW),
        .ROUTE_CHANS(ROUTE_CHANS), .ROUTE_W(ROUTE_W)
    ) u_dut (
        .clk(clk), .rst(rst), .chan_enabled(chan_enabled), .chan_active(chan_active),
        .tmr_alloc_fail(tmr_alloc_fail), .mod_win_close(mod_win_close),
        .seq_adv_code(seq_adv_code), .mod_mode(mod_mode), .cw_addr(cw_addr),
        .cw_step(cw_step), .thr_addr(thr_addr), .hold_addr(hold_addr),
        .tmr_addr(tmr_addr), .route_sel(route_sel), .out_a(out_a), .out_b(out_b),
        .out_c(out_c), .adc_max_set(adc_max_set), .open_ckt_set(open_ckt_set),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd_img(output logic [31:0] v);
        reg_rd = 1'b1;
        #1;
        v = reg_rdata;
        reg_rd = 1'b0;
        #0.5;
    endtask

    task automatic wr(input logic [31:0] d);
        reg_wr = 1'b1;
        reg_wdata = d;
        tick();
        reg_wr = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic idle_inputs();
        chan_enabled = 0; chan_active = 0; tmr_alloc_fail = 0; mod_win_close = 0;
        seq_adv_code = 0; mod_mode = 0; cw_addr = 0; cw_step = 0; thr_addr = 0;
        hold_addr = 0; tmr_addr = 0; route_sel = 0; adc_max_set = 0; open_ckt_set = 0;
    endtask

    task automatic apply_cause(input int c);
        case (c)
            1:  cw_addr = CW_AW'(CW_DEPTH);
            2:  begin cw_addr = CW_AW'(CW_DEPTH - 1); cw_step = 1; end
            3:  thr_addr = THR_AW'(THR_DEPTH);
            4:  hold_addr = HOLD_AW'(HOLD_DEPTH);
            5:  tmr_addr = TMR_AW'(TMR_DEPTH);
            6:  route_sel = ROUTE_W'(ROUTE_CHANS);
            7:  begin seq_adv_code = 2'b10; mod_mode = 2'b01; end
            8:  cw_addr = CW_AW'(CW_DEPTH - 1);
            9:  begin cw_addr = CW_AW'(CW_DEPTH - 2); cw_step = 1; end
            10: begin thr_addr = THR_AW'(THR_DEPTH - 1); route_sel = ROUTE_W'(ROUTE_CHANS - 1); end
            11: begin seq_adv_code = 2'b10; mod_mode = 2'b00; tmr_addr = TMR_AW'(TMR_DEPTH - 1); end
            default: ;
        endcase
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] img;
        @(negedge clk);
        repeat (3) tick();
        // R10: reset state and read gating
        rd_img(img);
        chk("R10 reset flags", img, 32'h0);
        adc_max_set = 1;
        tick();
        rst = 1'b1;
        adc_max_set = 0;
        tick();
        rst = 1'b0;
        rd_img(img);
        chk("R10 reset clears set flag", img, 32'h0);

        // R1 / R2 sweep over state, strobes and sequence codes
        for (int en = 0; en < 2; en++)
            for (int ac = 0; ac < 2; ac++)
                for (int fl = 0; fl < 2; fl++)
                    for (int wc = 0; wc < 2; wc++)
                        for (int sc = 0; sc < 4; sc++) begin
                            wr(CLR_ALL);
                            chan_enabled = en[0]; chan_active = ac[0];
                            tmr_alloc_fail = fl[0]; mod_win_close = wc[0];
                            seq_adv_code = sc[1:0];
                            tick();
                            idle_inputs();
                            rd_img(img);
                            chk("R1 timer alloc flag", 32'(img[6]), 32'(ac & fl));
                            chk("R2 sequence flag", 32'(img[7]), 32'(ac & wc & (sc != 0)));
                            chk("R3 no resource flag in R1/R2 sweep", 32'(img[8]), 32'h0);
                        end

        // R3 resource causes and in-range neighbours
        for (int c = 0; c < 12; c++)
            for (int en = 0; en < 2; en++) begin
                wr(CLR_ALL);
                chan_enabled = en[0]; chan_active = en[0];
                apply_cause(c);
                tick();
                idle_inputs();
                rd_img(img);
                chk("R3 resource flag", 32'(img[8]), 32'((en == 1) && (c >= 1) && (c <= 7)));
                chk("R3 other flags clear", img & 32'h000000C3, 32'h0);
            end

        // R4 live output monitor
        for (int st = 0; st < 4; st++)
            for (int v = 0; v < 8; v++) begin
                chan_enabled = st[0]; chan_active = st[1];
                {out_c, out_b, out_a} = v[2:0];
                rd_img(img);
                chk("R4 output monitor", 32'(img[11:9]), 32'(v));
            end
        idle_inputs();
        {out_c, out_b, out_a} = 3'b000;

        // set every flag
        wr(CLR_ALL);
        chan_active = 1; chan_enabled = 1; tmr_alloc_fail = 1; mod_win_close = 1;
        seq_adv_code = 2'b01; adc_max_set = 1; open_ckt_set = 1;
        tick();
        idle_inputs();
        chan_enabled = 1; thr_addr = THR_AW'(THR_DEPTH);
        tick();
        idle_inputs();
        rd_img(img);
        chk("R9 all flags set", img, 32'h000001C3);

        // R5 writes to non-clear bits change nothing, reserved reads zero
        wr(~CLR_ALL);
        rd_img(img);
        chk("R5 non-clear write no effect", img, 32'h000001C3);
        chk("R5 reserved and bits 19/20 zero", img & 32'hFFFFF03C, 32'h0);

        // R6 clear bits for the two external flags
        wr(32'h0);
        rd_img(img);
        chk("R6 zero write no effect", img, 32'h000001C3);
        wr(32'h00080000);
        rd_img(img);
        chk("R6 bit19 clears bit0", img, 32'h000001C2);
        wr(32'h00100000);
        rd_img(img);
        chk("R6 bit20 clears bit1", img, 32'h000001C0);

        // R7 per-flag clears
        wr(32'h00000040);
        rd_img(img);
        chk("R7 bit6 clear", img, 32'h00000180);
        wr(32'h00000080);
        rd_img(img);
        chk("R7 bit7 clear", img, 32'h00000100);
        wr(32'h00000100);
        rd_img(img);
        chk("R7 bit8 clear", img, 32'h00000000);

        // R8 set wins over simultaneous clear, for every flag
        chan_active = 1; chan_enabled = 1; tmr_alloc_fail = 1; mod_win_close = 1;
        seq_adv_code = 2'b11; adc_max_set = 1; open_ckt_set = 1; hold_addr = HOLD_AW'(HOLD_DEPTH);
        wr(CLR_ALL);
        idle_inputs();
        rd_img(img);
        chk("R8 set beats clear", img, 32'h000001C3);
        chan_enabled = 1; route_sel = ROUTE_W'(ROUTE_CHANS);
        wr(32'h00000100);
        rd_img(img);
        chk("R8 persistent resource cause re-sets", 32'(img[8]), 32'h1);
        idle_inputs();
        wr(32'h00000100);
        rd_img(img);
        chk("R8 clear after cause removed", 32'(img[8]), 32'h0);
        wr(CLR_ALL);

        // R9 external flags set in any state
        for (int st = 0; st < 4; st++) begin
            wr(CLR_ALL);
            chan_enabled = st[0]; chan_active = st[1];
            adc_max_set = 1;
            tick();
            adc_max_set = 0; open_ckt_set = 1;
            tick();
            idle_inputs();
            rd_img(img);
            chk("R9 external flags", img & 32'h3, 32'h3);
        end

        // R10 no read strobe gives zero
        #1;
        chk("R10 idle read zero", reg_rdata, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule